// File: doc/BRIEF.md
# Debounced Push-Button Up/Down Counter

This block turns two raw mechanical push-buttons into clean count steps. One button increments a 16-bit count and the other decrements it. The count drives a row of LEDs directly. Every flop runs on the single system clock, and no button ever acts as a clock or edge event.

Each button goes through a two-flop synchronizer and then a lockout conditioner. The conditioner acts on the first transition it sees. A press emits a one-cycle step pulse at once. After any accepted transition, the conditioner blanks its input for a hold-off of `HOLD_CYCLES` clock cycles. This applies to both press and release, so contact bounce in either direction is swallowed. The step pulses are brought out, and they advance the counter one cycle later.

Top module: `btn_updown_counter`

## Requirements
- R1: A synchronous active-high `rst` clears `led` to 0 and drops both step outputs. Both conditioners return to the released state with no hold-off running, so a press applied right after reset is taken at once.
- R2: A clean press, meaning a 0-to-1 change on a raw button input, raises that button's step output for exactly one cycle. The pulse comes on the third rising clock edge after the change.
- R3: Any changes on a button input during the `HOLD_CYCLES` cycles that follow an accepted press produce no further step pulse.
- R4: A release (1-to-0 change) produces no step pulse. It starts a new hold-off, so bounce around the release produces no pulse either.
- R5: A pulse on `step_up` alone raises `led` by one on the next clock edge. 0xFFFF wraps to 0x0000.
- R6: A pulse on `step_dn` alone lowers `led` by one on the next clock edge. 0x0000 wraps to 0xFFFF. Without a pulse, `led` holds its value.
- R7: If both step outputs pulse in the same cycle, `led` rises by one.
- R8: A level change that arrives during a hold-off and is still present when the hold-off ends is taken up then. A press held across the end of a release hold-off therefore yields one pulse, after that hold-off has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up_raw | input | 1 | Raw increment button, 1 = pressed |
| btn_dn_raw | input | 1 | Raw decrement button, 1 = pressed |
| step_up | output | 1 | One-cycle pulse for an accepted increment press |
| step_dn | output | 1 | One-cycle pulse for an accepted decrement press |
| led | output | COUNT_W (16) | Current count, one bit per LED |

## Verification
A raw press reaches its step output on the third rising edge after the change, and `led` follows one edge later. The bench changes inputs and samples outputs on falling edges, so it checks a step pulse on the third falling edge after the stimulus and the count on the fourth. Bounce bursts are always shorter than the hold-off. For these, the bench counts pulses on every falling edge and compares totals and the count only after the input has settled and the hold-off has run out. The one case meant to straddle a hold-off boundary (R8) is checked both inside and after the window.

// File: rtl/btn_updown_counter.sv
module btn_updown_counter #(
  parameter int unsigned HOLD_CYCLES = 50_000_000,
  parameter int unsigned COUNT_W     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               btn_up_raw,
  input  logic               btn_dn_raw,
  output logic               step_up,
  output logic               step_dn,
  output logic [COUNT_W-1:0] led
);
  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic [1:0] raw;
  logic [1:0] step;

  assign raw     = {btn_dn_raw, btn_up_raw};
  assign step_up = step[0];
  assign step_dn = step[1];

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic          meta, sync, lvl, pulse;
    logic [HW-1:0] hold;
    logic          quiet;

    assign quiet   = (hold == '0);
    assign step[i] = pulse;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta  <= 1'b0;
        sync  <= 1'b0;
        lvl   <= 1'b0;
        pulse <= 1'b0;
        hold  <= '0;
      end else begin
        meta  <= raw[i];
        sync  <= meta;
        pulse <= quiet && sync && !lvl;
        if (!quiet) begin
          hold <= hold - 1'b1;
        end else if (sync != lvl) begin
          lvl  <= sync;
          hold <= HW'(HOLD_CYCLES);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          led <= '0;
    else if (step[0]) led <= led + 1'b1;
    else if (step[1]) led <= led - 1'b1;
  end
endmodule

// File: rtl/btn_updown_counter_chk.sv
module btn_updown_counter_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         step_up,
  input logic         step_dn,
  input logic [W-1:0] led
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (led == '0 && !step_up && !step_dn));

  assert_up_single_R2: assert property (@(posedge clk) disable iff (rst)
    step_up |=> !step_up);

  assert_dn_single_R2: assert property (@(posedge clk) disable iff (rst)
    step_dn |=> !step_dn);

  assert_inc_R5: assert property (@(posedge clk) disable iff (rst)
    step_up |=> led == W'($past(led) + 1'b1));

  assert_dec_R6: assert property (@(posedge clk) disable iff (rst)
    (step_dn && !step_up) |=> led == W'($past(led) - 1'b1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!step_up && !step_dn) |=> $stable(led));
endmodule

bind btn_updown_counter btn_updown_counter_chk #(.W(COUNT_W)) u_chk (
  .clk(clk), .rst(rst), .step_up(step_up), .step_dn(step_dn), .led(led)
);

// File: tb/btn_updown_counter_tb.sv
module btn_updown_counter_tb;
  localparam int unsigned HOLD  = 40;
  localparam time         TCLK  = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_raw = 1'b0;
  logic        dn_raw = 1'b0;
  logic        step_up, step_dn;
  logic [15:0] led;

  int checks = 0;
  int errors = 0;
  int n_up = 0;
  int n_dn = 0;
  int unsigned model = 0;
  bit done = 1'b0;

  btn_updown_counter #(.HOLD_CYCLES(HOLD), .COUNT_W(16)) u_dut (
    .clk(clk), .rst(rst), .btn_up_raw(up_raw), .btn_dn_raw(dn_raw),
    .step_up(step_up), .step_dn(step_dn), .led(led)
  );

  always #(TCLK/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (step_up) n_up++;
      if (step_dn) n_dn++;
    end
  end

  function automatic int unsigned next_count(int unsigned c, bit up, bit dn);
    if (up)      return (c + 1) & 16'hFFFF;
    else if (dn) return (c + 16'hFFFF) & 16'hFFFF;
    return c;
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(bit u, bit d, bit v);
    if (u) up_raw = v;
    if (d) dn_raw = v;
  endtask

  task automatic bouncy(bit u, bit d, bit level);
    int nb = $urandom_range(0, 6);
    drive(u, d, level);
    cyc(1);
    for (int k = 0; k < nb; k++) begin
      drive(u, d, !level);
      cyc($urandom_range(1, 2));
      drive(u, d, level);
      cyc($urandom_range(1, 2));
    end
    cyc(HOLD + 10);
  endtask

  task automatic do_reset();
    rst = 1'b1; up_raw = 1'b0; dn_raw = 1'b0;
    cyc(3);
    rst = 1'b0;
    model = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bu, bd;
    void'($urandom(32'h5EED_1234));
    cyc(4);
    check("R1 led after reset", led, 0);
    check("R1 steps after reset", {step_up, step_dn}, 0);
    rst = 1'b0;
    cyc(2);

    up_raw = 1'b1;
    cyc(2);
    check("R2 no early pulse", step_up, 0);
    cyc(1);
    check("R2 pulse on third edge", step_up, 1);
    cyc(1);
    check("R2 pulse one cycle wide", step_up, 0);
    model = next_count(model, 1, 0);
    check("R5 increment", led, model);
    cyc(HOLD + 5);
    bu = n_up;
    bouncy(1, 0, 0);
    check("R4 release no pulse", n_up - bu, 0);

    for (int it = 0; it < 24; it++) begin
      int sel = $urandom_range(0, 2);
      bit u = (sel != 1);
      bit d = (sel != 0);
      bu = n_up; bd = n_dn;
      bouncy(u, d, 1);
      check("R3 one up pulse per press", n_up - bu, u);
      check("R3 one dn pulse per press", n_dn - bd, d);
      model = next_count(model, u, d);
      check(u && d ? "R7 both press" : (u ? "R5 up count" : "R6 down count"), led, model);
      bu = n_up; bd = n_dn;
      bouncy(u, d, 0);
      check("R4 bouncy release", (n_up - bu) + (n_dn - bd), 0);
      check("R4 count after release", led, model);
    end

    do_reset();
    cyc(1);
    bouncy(0, 1, 1);
    model = next_count(model, 0, 1);
    check("R6 wrap below zero", led, 16'hFFFF);
    bouncy(0, 1, 0);
    bouncy(1, 0, 1);
    model = next_count(model, 1, 0);
    check("R5 wrap above max", led, 0);

    cyc(5);
    up_raw = 1'b0;
    cyc(HOLD + 5);
    bu = n_up;
    up_raw = 1'b1;
    cyc(4);
    up_raw = 1'b0;
    cyc(8);
    up_raw = 1'b1;
    cyc(8);
    check("R3 reverse press inside window", n_up - bu, 1);
    up_raw = 1'b0;
    cyc(HOLD);
    bu = n_up;
    up_raw = 1'b1;
    cyc(HOLD + 20);
    check("R8 deferred press", n_up - bu, 1);
    model = 2;
    check("R8 deferred press count", led, model);

    up_raw = 1'b0;
    cyc(HOLD + 5);
    up_raw = 1'b1;
    cyc(6);
    rst = 1'b1; up_raw = 1'b0;
    cyc(2);
    rst = 1'b0;
    check("R1 led cleared mid hold-off", led, 0);
    bu = n_up;
    up_raw = 1'b1;
    cyc(3);
    check("R1 no hold-off after reset", step_up, 1);
    cyc(1);
    check("R1 count after reset press", led, 1);
    check("R2 single pulse after reset", n_up - bu, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule